// File: doc/BRIEF.md
# Clock-Relative Sync Pulse Position Detector

This block locates where a periodic sync pulse lands inside one period of the device clock. A bank of delayed sampling taps captures the pulse, and the captured values reach the block as one tap-sample vector per clock. Tap 0 has the smallest delay and the highest tap has the largest. The block treats a rise on tap 0 as one sync event. On each event it marks every tap that sits at or next to a 0/1 boundary in the vector, because a tap there is at risk of a setup or hold violation. Those marks are ORed into a status word, so the word grows over many events.

The status word always flags its lowest and highest tap. Nothing is known beyond either end of the tap range. A valid flag rises only once a minimum number of sync events has been counted. Software reads the status word, picks a tap that reads 0 (usually one in the middle of a clear run) and uses that tap as its capture point. If only the two end bits are set after several events, no boundary fell inside the range. This tells software to change the tap spacing.

The block also drives the tap-spacing control: fine or coarse. A synchronous restart input discards the collected history.

Top module: `sref_pos_detector`

## Requirements
- R1: After reset the status word reads 1 at tap 0 and at the top tap and 0 elsewhere (0x800001 for 24 taps). The valid flag is 0 and the spacing output is 1 (fine).
- R2: Bit 0 and the top bit of the status word read 1 in every cycle.
- R3: A sync event happens when tap 0 is 1 in the current sample and was 0 in the previous sample. The register for that previous sample resets to 1. On the clock edge that takes in an event, for every pair of adjacent taps k and k+1 that differ, bits k-1, k, k+1 and k+2 of the status word become 1. Indices outside the range are skipped. Bit 0 is the smallest delay.
- R4: Marks from separate events OR together. Without a restart, no status bit goes from 1 to 0.
- R5: The valid flag is 0 until 3 events have been taken in. It becomes 1 on the edge that takes in the third event and stays 1 through any further events.
- R6: A sample that is not an event changes neither the status word nor the valid flag. This includes any sample while tap 0 stays 1 or stays 0.
- R7: A restart clears the valid flag and the accumulated marks on the next edge, leaving only the end bits. If a restart and an event arrive in the same cycle, the restart wins.
- R8: An event whose sample has no adjacent-tap difference (for example all ones) adds no marks but still counts toward the valid flag.
- R9: The spacing output is a one-cycle registered copy of the spacing request input (1 = fine, 0 = coarse).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Synchronous clear of the history and the event count |
| tap_smp | input | 24 | Tap-sample vector, bit 0 = smallest delay |
| zoom_req | input | 1 | Requested tap spacing, 1 = fine |
| zoom_o | output | 1 | Registered tap-spacing control |
| pos_status | output | 24 | Accumulated risk map, 1 = unsafe tap |
| pos_valid | output | 1 | Enough events seen for the map to be trusted |

## Verification
A wrong event detector shows up as marks that appear while tap 0 is held high or low. It also shows up as a valid flag that rises after too few or too many events. Both can be seen on the edge right after the bad sample. A wrong mark span or an off-by-one tap index shows up as wrong bits in the status word one clock after a single known boundary. Boundaries placed near both ends of the range expose clipping errors. A restart that fails to clear, or an OR path that drops history, shows up within one event as a status word that differs from the union of the patterns applied.

// File: rtl/sref_pos_pkg.sv
package sref_pos_pkg;

   typedef enum logic {
      SPACING_COARSE = 1'b0,
      SPACING_FINE   = 1'b1
   } spacing_e;

   // Width needed to count up to and hold a limit value.
   function automatic int cnt_width(input int limit);
      int w;
      w = 1;
      while ((1 << w) <= limit) w++;
      return w;
   endfunction

endpackage

// File: rtl/sref_rise_detect.sv
module sref_rise_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_tap,
   output logic rise
);

   logic ref_q;

   // Reset to 1 so that a tap already high at reset release is not an event.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ref_q <= 1'b1;
      else        ref_q <= ref_tap;
   end

   assign rise = ref_tap & ~ref_q;

endmodule

// File: rtl/sref_mark_gen.sv
module sref_mark_gen #(
   parameter int NUM_TAPS = 24,
   parameter int GUARD    = 1
) (
   input  logic [NUM_TAPS-1:0] smp,
   output logic [NUM_TAPS-1:0] marks
);

   localparam int NUM_PAIRS = NUM_TAPS - 1;

   logic [NUM_PAIRS-1:0] diff;

   // One boundary detector per adjacent tap pair.
   for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
      assign diff[k] = smp[k] ^ smp[k+1];
   end

   // Tap j is marked by any boundary k with j-1-GUARD <= k <= j+GUARD.
   for (genvar j = 0; j < NUM_TAPS; j++) begin : g_tap
      localparam int LO_RAW = j - 1 - GUARD;
      localparam int HI_RAW = j + GUARD;
      localparam int LO     = (LO_RAW < 0) ? 0 : LO_RAW;
      localparam int HI     = (HI_RAW > NUM_PAIRS - 1) ? NUM_PAIRS - 1 : HI_RAW;
      localparam int SPAN   = HI - LO + 1;
      assign marks[j] = |diff[HI:LO];
      if (SPAN < 1) begin : g_bad_span
         $error("sref_mark_gen: empty mark window");
      end
   end

endmodule

// File: rtl/sref_edge_counter.sv
module sref_edge_counter #(
   parameter int EDGE_MIN = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output logic reached
);

   localparam int CNT_W = sref_pos_pkg::cnt_width(EDGE_MIN);
   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(EDGE_MIN);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cnt_q <= '0;
      else if (clr)                  cnt_q <= '0;
      else if (inc && cnt_q < LIMIT) cnt_q <= cnt_q + 1'b1;
   end

   assign reached = (cnt_q == LIMIT);

endmodule

// File: rtl/sref_pos_accum.sv
module sref_pos_accum #(
   parameter int NUM_TAPS = 24
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr,
   input  logic                load,
   input  logic [NUM_TAPS-1:0] marks,
   output logic [NUM_TAPS-1:0] status
);

   localparam logic [NUM_TAPS-1:0] END_MASK = {1'b1, {(NUM_TAPS-2){1'b0}}, 1'b1};

   logic [NUM_TAPS-1:0] acc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    acc_q <= '0;
      else if (clr)  acc_q <= '0;
      else if (load) acc_q <= acc_q | marks;
   end

   assign status = acc_q | END_MASK;

endmodule

// File: rtl/sref_pos_detector.sv
module sref_pos_detector #(
   parameter int NUM_TAPS   = 24,
   parameter int EDGE_MIN   = 3,
   parameter int GUARD      = 1,
   parameter bit ZOOM_RESET = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                restart,
   input  logic [NUM_TAPS-1:0] tap_smp,
   input  logic                zoom_req,
   output logic                zoom_o,
   output logic [NUM_TAPS-1:0] pos_status,
   output logic                pos_valid
);

   import sref_pos_pkg::*;

   if (NUM_TAPS < 4) begin : g_chk_taps
      $error("sref_pos_detector: NUM_TAPS must be at least 4");
   end
   if (EDGE_MIN < 1) begin : g_chk_edges
      $error("sref_pos_detector: EDGE_MIN must be at least 1");
   end
   if (GUARD < 0 || GUARD >= NUM_TAPS) begin : g_chk_guard
      $error("sref_pos_detector: GUARD out of range");
   end

   logic                evt;
   logic [NUM_TAPS-1:0] marks;
   spacing_e            zoom_q;

   sref_rise_detect u_rise (
      .clk     (clk),
      .rst_n   (rst_n),
      .ref_tap (tap_smp[0]),
      .rise    (evt)
   );

   sref_mark_gen #(
      .NUM_TAPS (NUM_TAPS),
      .GUARD    (GUARD)
   ) u_marks (
      .smp   (tap_smp),
      .marks (marks)
   );

   sref_edge_counter #(
      .EDGE_MIN (EDGE_MIN)
   ) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (restart),
      .inc     (evt),
      .reached (pos_valid)
   );

   sref_pos_accum #(
      .NUM_TAPS (NUM_TAPS)
   ) u_acc (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (restart),
      .load   (evt),
      .marks  (marks),
      .status (pos_status)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) zoom_q <= spacing_e'(ZOOM_RESET);
      else        zoom_q <= spacing_e'(zoom_req);
   end

   assign zoom_o = zoom_q;

endmodule

// File: rtl/sref_pos_detector_chk.sv
module sref_pos_detector_chk #(
   parameter int NUM_TAPS = 24
) (
   input logic                clk,
   input logic                rst_n,
   input logic                restart,
   input logic                evt,
   input logic                zoom_req,
   input logic                zoom_o,
   input logic [NUM_TAPS-1:0] pos_status,
   input logic                pos_valid
);

   localparam logic [NUM_TAPS-1:0] END_MASK = {1'b1, {(NUM_TAPS-2){1'b0}}, 1'b1};

   logic past_ok;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   // R2
   ends_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pos_status & END_MASK) == END_MASK);

   // R4
   no_bit_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !restart) |=> ((pos_status & $past(pos_status)) == $past(pos_status)));

   // R5
   valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pos_valid && !restart) |=> pos_valid);

   // R6
   quiet_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !restart && !evt) |=> ($stable(pos_status) && $stable(pos_valid)));

   // R7
   restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (!pos_valid && pos_status == END_MASK));

   // R9
   zoom_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |=> (zoom_o == $past(zoom_req)));

endmodule

bind sref_pos_detector sref_pos_detector_chk #(
   .NUM_TAPS (NUM_TAPS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .restart    (restart),
   .evt        (evt),
   .zoom_req   (zoom_req),
   .zoom_o     (zoom_o),
   .pos_status (pos_status),
   .pos_valid  (pos_valid)
);

// File: tb/sref_pos_detector_bench.sv
`timescale 1ns/1ps
module sref_pos_detector_bench;

   localparam int N = 24;
   localparam logic [N-1:0] ENDS = 24'h800001;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         restart = 1'b0;
   logic [N-1:0] tap_smp = '0;
   logic         zoom_req = 1'b1;
   logic         zoom_o;
   logic [N-1:0] pos_status;
   logic         pos_valid;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   sref_pos_detector u_sref_pos_detector (
      .clk(clk), .rst_n(rst_n), .restart(restart), .tap_smp(tap_smp),
      .zoom_req(zoom_req), .zoom_o(zoom_o),
      .pos_status(pos_status), .pos_valid(pos_valid)
   );

   task automatic chk(input bit ok, input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Expected marks from the requirement: boundary k marks taps k-1..k+2.
   function automatic logic [N-1:0] exp_marks(input logic [N-1:0] p);
      logic [N-1:0] m;
      m = '0;
      for (int k = 0; k < N-1; k++) begin
         if (p[k] != p[k+1]) begin
            for (int j = k-1; j <= k+2; j++)
               if (j >= 0 && j < N) m[j] = 1'b1;
         end
      end
      return m;
   endfunction

   function automatic logic [N-1:0] low_run(input int k);
      return (N'(1) << (k+1)) - N'(1);
   endfunction

   // Called at a negedge: one idle sample with tap 0 low, then the event sample.
   task automatic fire(input logic [N-1:0] p);
      tap_smp = '0;
      @(negedge clk);
      tap_smp = p;
      @(negedge clk);
      tap_smp = '0;
   endtask

   task automatic do_restart();
      restart = 1'b1;
      @(negedge clk);
      restart = 1'b0;
   endtask

   task automatic t_reset();
      chk(pos_status == ENDS, "R1 status", pos_status, ENDS);
      chk(pos_valid == 1'b0, "R1 valid", N'(pos_valid), '0);
      chk(zoom_o == 1'b1, "R1 zoom", N'(zoom_o), N'(1));
      chk(pos_status[0] && pos_status[N-1], "R2 ends", pos_status, ENDS);
   endtask

   task automatic t_single();
      logic [N-1:0] e;
      do_restart();
      fire(low_run(5));
      e = ENDS | exp_marks(low_run(5));
      chk(pos_status == e, "R3 boundary 5/6", pos_status, e);
      chk(pos_status == 24'h8000F1, "R3 literal", pos_status, 24'h8000F1);
      do_restart();
      fire(low_run(0));
      e = ENDS | 24'h7;
      chk(pos_status == e, "R3 low clip", pos_status, e);
      do_restart();
      fire(24'h7FFFFF);
      e = ENDS | 24'hE00000;
      chk(pos_status == e, "R3 high clip", pos_status, e);
   endtask

   task automatic t_accum();
      logic [N-1:0] e;
      do_restart();
      fire(low_run(3));
      fire(low_run(12));
      e = ENDS | exp_marks(low_run(3)) | exp_marks(low_run(12));
      chk(pos_status == e, "R4 accumulate", pos_status, e);
      fire(low_run(3));
      chk(pos_status == e, "R4 repeat same", pos_status, e);
   endtask

   task automatic t_count();
      do_restart();
      fire(low_run(8));
      chk(pos_valid == 1'b0, "R5 after 1", N'(pos_valid), '0);
      fire(low_run(8));
      chk(pos_valid == 1'b0, "R5 after 2", N'(pos_valid), '0);
      fire(low_run(8));
      chk(pos_valid == 1'b1, "R5 after 3", N'(pos_valid), N'(1));
      fire(low_run(8));
      fire(low_run(8));
      chk(pos_valid == 1'b1, "R5 saturate", N'(pos_valid), N'(1));
   endtask

   task automatic t_no_event();
      logic [N-1:0] e;
      do_restart();
      tap_smp = '0;
      @(negedge clk);
      tap_smp = 24'h0F0F00;
      repeat (3) @(negedge clk);
      chk(pos_status == ENDS, "R6 tap0 low", pos_status, ENDS);
      tap_smp = low_run(4);
      @(negedge clk);
      e = ENDS | exp_marks(low_run(4));
      tap_smp = low_run(15);
      repeat (3) @(negedge clk);
      tap_smp = 24'h0FF0F1;
      repeat (2) @(negedge clk);
      chk(pos_status == e, "R6 tap0 held high", pos_status, e);
      chk(pos_valid == 1'b0, "R6 single count", N'(pos_valid), '0);
      tap_smp = '0;
      @(negedge clk);
   endtask

   task automatic t_restart();
      fire(low_run(10));
      fire(low_run(10));
      fire(low_run(10));
      do_restart();
      chk(pos_status == ENDS, "R7 clear status", pos_status, ENDS);
      chk(pos_valid == 1'b0, "R7 clear valid", N'(pos_valid), '0);
      tap_smp = '0;
      @(negedge clk);
      tap_smp = low_run(9);
      restart = 1'b1;
      @(negedge clk);
      restart = 1'b0;
      tap_smp = '0;
      chk(pos_status == ENDS, "R7 collision", pos_status, ENDS);
      fire(low_run(2));
      fire(low_run(2));
      chk(pos_valid == 1'b0, "R7 collision not counted", N'(pos_valid), '0);
   endtask

   task automatic t_no_transition();
      do_restart();
      fire('1);
      fire('1);
      fire('1);
      chk(pos_status == ENDS, "R8 only ends", pos_status, ENDS);
      chk(pos_valid == 1'b1, "R8 counted", N'(pos_valid), N'(1));
   endtask

   task automatic t_zoom();
      zoom_req = 1'b0;
      @(posedge clk);
      #1;
      chk(zoom_o == 1'b0, "R9 coarse", N'(zoom_o), '0);
      zoom_req = 1'b1;
      @(posedge clk);
      #1;
      chk(zoom_o == 1'b1, "R9 fine", N'(zoom_o), N'(1));
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single();
      t_accum();
      t_count();
      t_no_event();
      t_restart();
      t_no_transition();
      t_zoom();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule